// File: doc/BRIEF.md
# Power Slice On/Off Sequencer

This block brings one switchable power slice up and down in a safe order. It drives four controls: a handshake request to the security agent that guards the slice, the isolation clamps on the slice outputs, the slice reset, and the power switch. During an automatic sequence it changes one control at a time. It then waits until the matching status input confirms the new state, and only after that does it move on to the next control.

Three control sources share the slice, and a small register bank selects between them. Software can write the four controls directly. Software can toggle a single power-down bit, which runs the whole off or on sequence in hardware. With the low-power select bit set, a table of sixteen 4-bit per-domain power levels decides the target state: the level of the CPU domain named on an input is compared with the level the slice needs. A programmable cycle limit bounds each wait for an acknowledge.

Top module: `slice_pwr_seq`

## Requirements
- R1: After reset all four controls are inactive (hs_req, iso_en, rst_assert, psw_open all 0), busy is 0 and tmo_err is 0.
- R2: A power-down sequence raises hs_req, then iso_en, then rst_assert, then psw_open. Each control is raised only after the status input of the previous step confirms it.
- R3: A power-up sequence runs in the reverse order: psw_open falls, then rst_assert, then iso_en, then hs_req. Each control falls only after the previous step's status shows it inactive.
- R4: Status polarity: hs_ack, iso_ack and psw_ack are 1 while their condition is active, and rst_released is 0 while reset is asserted. The reset step of a power-down completes only once rst_released reads 0. The reset step of a power-up completes only once it reads 1.
- R5: Register CTRL (address 0) has these bits: [0] handshake, [1] isolation, [2] reset, [3] power switch, [4] power-down, [5] low-power select. A CTRL write with bit 5 clear and bit 4 unchanged copies bits [3:0] onto the four controls on the next clock edge.
- R6: A CTRL write with bit 5 clear that changes bit 4 from 0 to 1 starts a power-down sequence. A change from 1 to 0 starts a power-up sequence. Bits [3:0] of that write are ignored.
- R7: busy is 1 for as long as an automatic sequence runs. A CTRL write made while busy is 1 is ignored entirely.
- R8: While low-power select is set, CTRL bits [3:0] have no effect. The slice powers down when the level of domain cpu_dom is below need_level, and powers up when that level is at or above need_level.
- R9: Domain levels are held in LVL_A (address 1) for domains 0 to 7 and LVL_B (address 2) for domains 8 to 15. Domain n occupies bits [4*(n mod 8)+3 : 4*(n mod 8)].
- R10: If a step's acknowledge is still missing after more than TMO (address 3, bits [15:0]) cycles, tmo_err is set and stays set. The sequencer holds that step and resumes once the acknowledge arrives.
- R11: Register STATUS (address 4) reads as follows: [0] hs_ack, [1] iso_ack, [2] rst_released, [3] psw_ack, [4] busy, [5] tmo_err. Reading CTRL returns the current controls in [3:0], the power-down bit in [4] and low-power select in [5].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| hs_ack | input | 1 | Security handshake acknowledged |
| iso_ack | input | 1 | Isolation clamps engaged |
| rst_released | input | 1 | Slice reset status, 0 while in reset |
| psw_ack | input | 1 | Power switch open |
| cpu_dom | input | 4 | Index of the active CPU domain |
| need_level | input | 4 | Level the slice needs to stay powered |
| hs_req | output | 1 | Handshake request |
| iso_en | output | 1 | Isolation enable |
| rst_assert | output | 1 | Slice reset assert |
| psw_open | output | 1 | Power switch open |
| busy | output | 1 | Automatic sequence running |
| tmo_err | output | 1 | Sticky acknowledge timeout |

## Verification
The bench stalls the reset acknowledge in both directions. A design that treated reset status with the same polarity as the other stages would run straight past the reset step instead of holding at 0111 or 0011. It logs every control edge to prove the order in each direction, so a swapped stage would show up in the log. It writes CTRL during a running sequence, where a design that still accepted the write would load stray controls or drop low-power mode. It also holds the switch acknowledge past a short timeout, where a design without a sticky flag or a hold would either clear the error or finish early.

// File: rtl/slice_pwr_pkg.sv
`timescale 1ns/1ps
package slice_pwr_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 3;
  localparam int N_STAGE = 4;
  localparam int STG_IW  = $clog2(N_STAGE);

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_LVL_A  = 3'd1;
  localparam logic [ADDR_W-1:0] A_LVL_B  = 3'd2;
  localparam logic [ADDR_W-1:0] A_TMO    = 3'd3;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;

  localparam int B_PDN = 4;
  localparam int B_LPM = 5;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_DOWN = 2'd1,
    SQ_UP   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/slice_pwr_lvl.sv
`timescale 1ns/1ps
module slice_pwr_lvl #(
  parameter int N_DOM = 16,
  parameter int LVL_W = 4,
  parameter int REG_W = 32,
  localparam int PER_REG = REG_W / LVL_W,
  localparam int DOM_W   = $clog2(N_DOM)
) (
  input  logic [REG_W-1:0] lvl_a,
  input  logic [REG_W-1:0] lvl_b,
  input  logic [DOM_W-1:0] cpu_dom,
  input  logic [LVL_W-1:0] need_level,
  output logic             want_off
);
  logic [LVL_W-1:0] dom_lvl [N_DOM];

  for (genvar g = 0; g < N_DOM; g++) begin : g_dom
    if (g < PER_REG) begin : g_lo
      assign dom_lvl[g] = lvl_a[(g % PER_REG)*LVL_W +: LVL_W];
    end else begin : g_hi
      assign dom_lvl[g] = lvl_b[(g % PER_REG)*LVL_W +: LVL_W];
    end
  end

  assign want_off = dom_lvl[cpu_dom] < need_level;
endmodule

// File: rtl/slice_pwr_regs.sv
`timescale 1ns/1ps
module slice_pwr_regs
  import slice_pwr_pkg::*;
#(
  parameter int TMO_W     = 16,
  parameter int TMO_RESET = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [REG_W-1:0]   rd_data,
  input  logic               busy,
  input  logic               err,
  input  logic [N_STAGE-1:0] ctl_cur,
  input  logic [N_STAGE-1:0] ack_raw,
  output logic [REG_W-1:0]   lvl_a,
  output logic [REG_W-1:0]   lvl_b,
  output logic [TMO_W-1:0]   tmo_limit,
  output logic               lpm_on,
  output logic               ctrl_ok,
  output logic               sw_load,
  output logic [N_STAGE-1:0] sw_bits,
  output logic               sw_down,
  output logic               sw_up
);
  logic pdn_q;
  logic new_pdn, new_lpm;
  logic lvl_a_we, lvl_b_we, tmo_we;

  assign ctrl_ok  = wr_en && (wr_addr == A_CTRL) && !busy;
  assign lvl_a_we = wr_en && (wr_addr == A_LVL_A);
  assign lvl_b_we = wr_en && (wr_addr == A_LVL_B);
  assign tmo_we   = wr_en && (wr_addr == A_TMO);
  assign new_pdn  = wr_data[B_PDN];
  assign new_lpm  = wr_data[B_LPM];

  assign sw_bits = wr_data[N_STAGE-1:0];
  assign sw_load = ctrl_ok && !new_lpm && (new_pdn == pdn_q);
  assign sw_down = ctrl_ok && !new_lpm && new_pdn && !pdn_q;
  assign sw_up   = ctrl_ok && !new_lpm && !new_pdn && pdn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdn_q  <= 1'b0;
      lpm_on <= 1'b0;
    end else if (ctrl_ok) begin
      pdn_q  <= new_pdn;
      lpm_on <= new_lpm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_a <= '0;
    else if (lvl_a_we) lvl_a <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_b <= '0;
    else if (lvl_b_we) lvl_b <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmo_limit <= TMO_W'(TMO_RESET);
    else if (tmo_we) tmo_limit <= wr_data[TMO_W-1:0];
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[N_STAGE-1:0] = ctl_cur;
        rd_data[B_PDN]       = pdn_q;
        rd_data[B_LPM]       = lpm_on;
      end
      A_LVL_A:  rd_data = lvl_a;
      A_LVL_B:  rd_data = lvl_b;
      A_TMO:    rd_data[TMO_W-1:0] = tmo_limit;
      A_STATUS: begin
        rd_data[N_STAGE-1:0] = ack_raw;
        rd_data[N_STAGE]     = busy;
        rd_data[N_STAGE+1]   = err;
      end
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/slice_pwr_fsm.sv
`timescale 1ns/1ps
module slice_pwr_fsm
  import slice_pwr_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_down,
  input  logic               req_up,
  input  logic               sw_load,
  input  logic [N_STAGE-1:0] sw_bits,
  input  logic [N_STAGE-1:0] ack_act,
  input  logic [TMO_W-1:0]   tmo_limit,
  output logic [N_STAGE-1:0] ctl_q,
  output logic               busy,
  output logic               err_q
);
  localparam logic [STG_IW-1:0] LAST_IDX = STG_IW'(N_STAGE - 1);
  localparam logic [TMO_W-1:0]  CNT_MAX  = '1;

  seq_state_e         st_q, st_n;
  logic [STG_IW-1:0]  idx_q, idx_n, idx_inc, idx_dec;
  logic [N_STAGE-1:0] ctl_n;
  logic [TMO_W-1:0]   cnt_q, cnt_n;
  logic               err_n;

  assign idx_inc = idx_q + 1'b1;
  assign idx_dec = idx_q - 1'b1;
  assign busy    = (st_q != SQ_IDLE);

  always_comb begin
    st_n  = st_q;
    idx_n = idx_q;
    ctl_n = ctl_q;
    cnt_n = cnt_q;
    err_n = err_q;
    case (st_q)
      SQ_IDLE: begin
        if (req_down) begin
          st_n        = SQ_DOWN;
          idx_n       = '0;
          ctl_n[0]    = 1'b1;
          cnt_n       = '0;
        end else if (req_up) begin
          st_n            = SQ_UP;
          idx_n           = LAST_IDX;
          ctl_n[LAST_IDX] = 1'b0;
          cnt_n           = '0;
        end else if (sw_load) begin
          ctl_n = sw_bits;
        end
      end
      SQ_DOWN: begin
        if (ack_act[idx_q]) begin
          cnt_n = '0;
          if (idx_q == LAST_IDX) begin
            st_n = SQ_IDLE;
          end else begin
            idx_n          = idx_inc;
            ctl_n[idx_inc] = 1'b1;
          end
        end else begin
          if (cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
          if (cnt_q >= tmo_limit) err_n = 1'b1;
        end
      end
      SQ_UP: begin
        if (!ack_act[idx_q]) begin
          cnt_n = '0;
          if (idx_q == '0) begin
            st_n = SQ_IDLE;
          end else begin
            idx_n          = idx_dec;
            ctl_n[idx_dec] = 1'b0;
          end
        end else begin
          if (cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
          if (cnt_q >= tmo_limit) err_n = 1'b1;
        end
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      idx_q <= '0;
      ctl_q <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      idx_q <= idx_n;
      ctl_q <= ctl_n;
      cnt_q <= cnt_n;
      err_q <= err_n;
    end
  end
endmodule

// File: rtl/slice_pwr_seq.sv
`timescale 1ns/1ps
module slice_pwr_seq
  import slice_pwr_pkg::*;
#(
  parameter int N_DOM     = 16,
  parameter int LVL_W     = 4,
  parameter int TMO_W     = 16,
  parameter int TMO_RESET = 1000,
  localparam int DOM_W    = $clog2(N_DOM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              hs_ack,
  input  logic              iso_ack,
  input  logic              rst_released,
  input  logic              psw_ack,
  input  logic [DOM_W-1:0]  cpu_dom,
  input  logic [LVL_W-1:0]  need_level,
  output logic              hs_req,
  output logic              iso_en,
  output logic              rst_assert,
  output logic              psw_open,
  output logic              busy,
  output logic              tmo_err
);
  logic [N_STAGE-1:0] ctl_q, ack_raw, ack_act, sw_bits;
  logic [REG_W-1:0]   lvl_a, lvl_b;
  logic [TMO_W-1:0]   tmo_limit;
  logic lpm_on, ctrl_ok, sw_load, sw_down, sw_up, want_off;
  logic lpm_down, lpm_up, req_down, req_up;

  assign ack_raw = {psw_ack, rst_released, iso_ack, hs_ack};
  assign ack_act = {psw_ack, ~rst_released, iso_ack, hs_ack};

  slice_pwr_regs #(.TMO_W(TMO_W), .TMO_RESET(TMO_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .err(tmo_err), .ctl_cur(ctl_q), .ack_raw(ack_raw),
    .lvl_a(lvl_a), .lvl_b(lvl_b), .tmo_limit(tmo_limit), .lpm_on(lpm_on),
    .ctrl_ok(ctrl_ok), .sw_load(sw_load), .sw_bits(sw_bits),
    .sw_down(sw_down), .sw_up(sw_up)
  );

  slice_pwr_lvl #(.N_DOM(N_DOM), .LVL_W(LVL_W), .REG_W(REG_W)) u_lvl (
    .lvl_a(lvl_a), .lvl_b(lvl_b), .cpu_dom(cpu_dom),
    .need_level(need_level), .want_off(want_off)
  );

  assign lpm_down = lpm_on && !ctrl_ok && want_off  && (ctl_q != '1);
  assign lpm_up   = lpm_on && !ctrl_ok && !want_off && (ctl_q != '0);
  assign req_down = sw_down | lpm_down;
  assign req_up   = sw_up | lpm_up;

  slice_pwr_fsm #(.TMO_W(TMO_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_down(req_down), .req_up(req_up),
    .sw_load(sw_load), .sw_bits(sw_bits), .ack_act(ack_act),
    .tmo_limit(tmo_limit), .ctl_q(ctl_q), .busy(busy), .err_q(tmo_err)
  );

  assign hs_req     = ctl_q[0];
  assign iso_en     = ctl_q[1];
  assign rst_assert = ctl_q[2];
  assign psw_open   = ctl_q[3];
endmodule

// File: rtl/slice_pwr_seq_chk.sv
`timescale 1ns/1ps
module slice_pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic hs_req,
  input logic iso_en,
  input logic rst_assert,
  input logic psw_open,
  input logic hs_ack,
  input logic iso_ack,
  input logic rst_released,
  input logic busy,
  input logic tmo_err
);
  // R2
  iso_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(iso_en) && $past(busy)) |-> $past(hs_ack));

  // R2
  psw_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(psw_open) && $past(busy)) |-> $past(!rst_released));

  // R3
  iso_off_after_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(iso_en) && $past(busy)) |-> $past(rst_released));

  // R3
  hs_off_after_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hs_req) && $past(busy)) |-> $past(!iso_ack));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |=> tmo_err);

  // R10
  err_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_err) |-> busy);

  // R4
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_assert) && $past(busy)) |-> $past(iso_ack));
endmodule

bind slice_pwr_seq slice_pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .iso_en(iso_en),
  .rst_assert(rst_assert), .psw_open(psw_open), .hs_ack(hs_ack),
  .iso_ack(iso_ack), .rst_released(rst_released), .busy(busy),
  .tmo_err(tmo_err)
);

// File: tb/slice_pwr_seq_test.sv
`timescale 1ns/1ps
module slice_pwr_seq_test;
  logic        clk, rst_n, wr_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        hs_ack, iso_ack, rst_released, psw_ack;
  logic [3:0]  cpu_dom, need_level;
  logic        hs_req, iso_en, rst_assert, psw_open, busy, tmo_err;
  logic        stall_rst, stall_psw;
  int          n_chk, n_bad;
  logic [2:0]  ev [16];
  int          ev_n;
  logic [3:0]  prev_ctl;

  slice_pwr_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .hs_ack(hs_ack), .iso_ack(iso_ack), .rst_released(rst_released),
    .psw_ack(psw_ack), .cpu_dom(cpu_dom), .need_level(need_level),
    .hs_req(hs_req), .iso_en(iso_en), .rst_assert(rst_assert),
    .psw_open(psw_open), .busy(busy), .tmo_err(tmo_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // slice model: each acknowledge follows its control one cycle later
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_ack <= 1'b0; iso_ack <= 1'b0; rst_released <= 1'b1; psw_ack <= 1'b0;
    end else begin
      hs_ack  <= hs_req;
      iso_ack <= iso_en;
      if (!stall_rst) rst_released <= !rst_assert;
      if (!stall_psw) psw_ack <= psw_open;
    end
  end

  // edge log: {rise, stage index}
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 4; i++) begin
        if ({psw_open, rst_assert, iso_en, hs_req}[i] != prev_ctl[i] && ev_n < 16) begin
          ev[ev_n] = {prev_ctl[i] ? 1'b0 : 1'b1, 2'(i)};
          ev_n++;
        end
      end
    end
    prev_ctl = {psw_open, rst_assert, iso_en, hs_req};
  end

  // {addr, data, extra wait, expected {psw,rst,iso,hs}, expected busy}
  localparam int NV = 17;
  localparam logic [47:0] VEC [NV] = '{
    {3'd0, 32'h0000_0001, 8'd0,  4'b0001, 1'b0},  // R5
    {3'd0, 32'h0000_0003, 8'd0,  4'b0011, 1'b0},  // R5
    {3'd0, 32'h0000_0000, 8'd0,  4'b0000, 1'b0},  // R5
    {3'd0, 32'h0000_0010, 8'd0,  4'b0001, 1'b1},  // R6 start down
    {3'd0, 32'h0000_0003, 8'd20, 4'b1111, 1'b0},  // R7 write while busy ignored
    {3'd0, 32'h0000_0017, 8'd0,  4'b0111, 1'b0},  // R5 pdn unchanged
    {3'd0, 32'h0000_0000, 8'd0,  4'b0111, 1'b1},  // R6 start up
    {3'd3, 32'h0000_0064, 8'd20, 4'b0000, 1'b0},  // R6 up done
    {3'd2, 32'h0000_0050, 8'd1,  4'b0000, 1'b0},  // R9 dom9 = 5
    {3'd0, 32'h0000_002F, 8'd20, 4'b0000, 1'b0},  // R8 steps ignored in lpm
    {3'd2, 32'h0000_0030, 8'd20, 4'b1111, 1'b0},  // R8 dom9 = 3 < 4
    {3'd1, 32'h0000_0090, 8'd20, 4'b1111, 1'b0},  // R9 other register
    {3'd2, 32'h0000_00F0, 8'd1,  4'b0111, 1'b1},  // R8 level >= need
    {3'd0, 32'h0000_000F, 8'd20, 4'b0000, 1'b0},  // R7 ignored while busy
    {3'd0, 32'h0000_0000, 8'd0,  4'b0000, 1'b0},  // R5 lpm off
    {3'd0, 32'h0000_0005, 8'd0,  4'b0101, 1'b0},  // R5
    {3'd0, 32'h0000_0000, 8'd0,  4'b0000, 1'b0}   // R5
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [3:0] ctl();
    return {psw_open, rst_assert, iso_en, hs_req};
  endfunction

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic expect_log(input logic [2:0] e0, input logic [2:0] e1,
                            input logic [2:0] e2, input logic [2:0] e3,
                            input string req);
    check(ev_n == 4 && ev[0] == e0 && ev[1] == e1 && ev[2] == e2 && ev[3] == e3,
          req, {ev[0], ev[1], ev[2], ev[3], 4'(ev_n)},
          {e0, e1, e2, e3, 4'd4});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    n_chk = 0; n_bad = 0; ev_n = 0; prev_ctl = 4'b0000;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    cpu_dom = 4'd9; need_level = 4'd4; stall_rst = 1'b0; stall_psw = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check(ctl() == 4'b0000 && !busy && !tmo_err, "R1",
          {26'd0, tmo_err, busy, ctl()}, 32'd0);
    // R11 status layout after reset: only rst_released set
    rd(3'd4, r);
    check(r == 32'h0000_0004, "R11", r, 32'h4);

    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][47:45], VEC[v][44:13]);
      idle(int'(VEC[v][12:5]));
      check(ctl() == VEC[v][4:1] && busy == VEC[v][0], "R5-table vector",
            {27'd0, busy, ctl()}, {27'd0, VEC[v][0], VEC[v][4:1]});
    end

    // R11 CTRL readback: controls 0, pdn 0, lpm 0
    rd(3'd0, r);
    check(r == 32'h0, "R11", r, 32'h0);

    // R2 down order
    ev_n = 0;
    wr(3'd0, 32'h10);
    idle(20);
    expect_log(3'b100, 3'b101, 3'b110, 3'b111, "R2");
    // R3 up order
    ev_n = 0;
    wr(3'd0, 32'h00);
    idle(20);
    expect_log(3'b011, 3'b010, 3'b001, 3'b000, "R3");

    // R4 reset status polarity, down direction
    stall_rst = 1'b1;
    wr(3'd0, 32'h10);
    idle(20);
    check(ctl() == 4'b0111 && busy, "R4", {27'd0, busy, ctl()}, 32'h17);
    stall_rst = 1'b0;
    idle(20);
    check(ctl() == 4'b1111 && !busy && !tmo_err, "R4",
          {26'd0, tmo_err, busy, ctl()}, 32'h0F);
    // R4 up direction
    stall_rst = 1'b1;
    wr(3'd0, 32'h00);
    idle(20);
    check(ctl() == 4'b0011 && busy, "R4", {27'd0, busy, ctl()}, 32'h13);
    stall_rst = 1'b0;
    idle(20);
    check(ctl() == 4'b0000 && !busy, "R4", {27'd0, busy, ctl()}, 32'h00);

    // R10 timeout
    wr(3'd3, 32'd5);
    stall_psw = 1'b1;
    wr(3'd0, 32'h10);
    idle(30);
    rd(3'd4, r);
    check(r[5:4] == 2'b11 && ctl() == 4'b1111, "R10",
          {r[31:4], ctl()}, 32'h3F);
    stall_psw = 1'b0;
    idle(10);
    rd(3'd4, r);
    check(r == 32'h0000_002B && !busy && tmo_err, "R10", r, 32'h2B);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule